// File: doc/BRIEF.md
# Dual 16-bit Interval Timer

This block holds two 16-bit down-counters behind a byte-wide, 16-address register port. The first counter has a full 16-bit reload latch that software can reach as two bytes. It either fires once or runs free and reloads itself, depending on one bit of an auxiliary control byte that the block also holds. The second counter always fires once and keeps only a low-byte latch. Its high byte arrives with the write that starts it.

Both counters step down once for each cycle in which the tick-enable strobe is high. When a counter arrives at zero, the block sends a one-cycle event pulse to the interrupt flag unit that sits beside it. The block does not own the interrupt flags. It sends a separate one-cycle clear request to that unit whenever a register access should drop a timer's flag. Reads are combinational. Register writes, event pulses and clear requests take effect at the clock edge that ends the access or tick cycle.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both timer-1 latch bytes and both timer-1 counter bytes read 0xFF. Both timer-2 counter bytes read 0xFF, the auxiliary byte reads 0x00, and no event or clear output is high.
- R2: A write to address 4 or address 6 changes only the low byte of the timer-1 latch. The timer-1 counter keeps its value. Address 6 reads the latch low byte and address 7 reads the latch high byte.
- R3: A write to address 5 stores the latch high byte, loads the counter with {written byte, latch low byte} and arms timer 1. It also raises `t1_flag_clr` for the following cycle. A tick in the same cycle as this write is ignored.
- R4: A write to address 7 changes only the latch high byte and raises `t1_flag_clr` for the following cycle. The counter is not reloaded.
- R5: Each counter decrements by one per tick-enable cycle and holds otherwise. Addresses 4 and 5 read the live timer-1 counter low and high bytes. Addresses 8 and 9 read the live timer-2 counter low and high bytes.
- R6: An event output is a one-cycle pulse. It is high in the cycle in which the counter first reads 0 after a tick, and only while that timer is armed.
- R7: With auxiliary bit 6 at 0 (one-shot), timer 1 fires once per start. Its counter keeps counting down through 0xFFFF without reloading and gives no further event.
- R8: With auxiliary bit 6 at 1 (free-running), the tick after the counter reads 0xFFFF loads the current latch value. Events repeat every latch+2 ticks, and this includes a latch of 0.
- R9: A write to address 8 stores the timer-2 latch low byte only. A write to address 9 loads the timer-2 counter with {written byte, latch low byte}, arms timer 2 and raises `t2_flag_clr` for the following cycle. Timer 2 fires once, then wraps and keeps counting without firing until address 9 is written again.
- R10: A read of address 4 raises `t1_flag_clr` and a read of address 8 raises `t2_flag_clr`, each for the following cycle. A read of address 5 or address 9 raises no clear request.
- R11: Address 11 is the 8-bit auxiliary byte and can be read and written. Addresses 0-3, 10 and 12-15 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count strobe; both counters step once per high cycle |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_rd | input | 1 | Read strobe, qualified by `bus_sel` |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when no read |
| t1_evt | output | 1 | Timer-1 zero event pulse |
| t2_evt | output | 1 | Timer-2 zero event pulse |
| t1_flag_clr | output | 1 | Clear request for the timer-1 interrupt flag |
| t2_flag_clr | output | 1 | Clear request for the timer-2 interrupt flag |

## Verification
The bench places the free-running events at exact tick numbers. A design that reloaded on the zero state rather than after 0xFFFF would show a period of latch+1, and a latch of 0 would then never fire. It also checks that a one-shot counter reads 0xFFFD three ticks after its event: a design that reloaded or stopped would read the latch or 0 there. The bench writes the low latch and the high latch while the counter holds a non-latch value, so a design that reloaded on those writes would show the latch too early. Reads of the high counter bytes must raise no clear request, and a second write to address 9 must re-arm timer 2, which a design that latched its fired state would miss.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  // Register addresses: the start side effects hang on these exact values.
  localparam logic [ADDR_W-1:0] A_T1_CLO = 4'd4;
  localparam logic [ADDR_W-1:0] A_T1_CHI = 4'd5;
  localparam logic [ADDR_W-1:0] A_T1_LLO = 4'd6;
  localparam logic [ADDR_W-1:0] A_T1_LHI = 4'd7;
  localparam logic [ADDR_W-1:0] A_T2_LO  = 4'd8;
  localparam logic [ADDR_W-1:0] A_T2_HI  = 4'd9;
  localparam logic [ADDR_W-1:0] A_AUX    = 4'd11;

  typedef struct packed {
    logic t1_lo_wr;     // low latch byte
    logic t1_start;     // high byte + transfer + arm
    logic t1_hi_wr;     // high latch byte only
    logic t2_lo_wr;
    logic t2_start;
    logic aux_wr;
    logic t1_lo_rd;
    logic t2_lo_rd;
  } dit_strobes_t;
endpackage

// File: rtl/dit_bus_decode.sv
module dit_bus_decode
  import dit_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     t1_cnt_i,
  input  logic [CW-1:0]     t1_latch_i,
  input  logic [CW-1:0]     t2_cnt_i,
  input  logic [DW-1:0]     aux_i,
  output dit_strobes_t      stb_o,
  output logic [DW-1:0]     rdata_o
);
  logic wr_acc, rd_acc;

  assign wr_acc = sel_i & wr_i;
  assign rd_acc = sel_i & rd_i;

  always_comb begin
    stb_o          = '0;
    stb_o.t1_lo_wr = wr_acc & ((addr_i == A_T1_CLO) | (addr_i == A_T1_LLO));
    stb_o.t1_start = wr_acc & (addr_i == A_T1_CHI);
    stb_o.t1_hi_wr = wr_acc & (addr_i == A_T1_LHI);
    stb_o.t2_lo_wr = wr_acc & (addr_i == A_T2_LO);
    stb_o.t2_start = wr_acc & (addr_i == A_T2_HI);
    stb_o.aux_wr   = wr_acc & (addr_i == A_AUX);
    stb_o.t1_lo_rd = rd_acc & (addr_i == A_T1_CLO);
    stb_o.t2_lo_rd = rd_acc & (addr_i == A_T2_LO);
  end

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      case (addr_i)
        A_T1_CLO: rdata_o = t1_cnt_i[DW-1:0];
        A_T1_CHI: rdata_o = t1_cnt_i[CW-1:DW];
        A_T1_LLO: rdata_o = t1_latch_i[DW-1:0];
        A_T1_LHI: rdata_o = t1_latch_i[CW-1:DW];
        A_T2_LO:  rdata_o = t2_cnt_i[DW-1:0];
        A_T2_HI:  rdata_o = t2_cnt_i[CW-1:DW];
        A_AUX:    rdata_o = aux_i;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dit_count_unit.sv
module dit_count_unit #(
  parameter int          CW         = 16,
  parameter bit          HAS_RELOAD = 1'b1,
  parameter logic [CW-1:0] RST_VAL  = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] reload_val_i,
  input  logic          cont_i,
  output logic [CW-1:0] cnt_o,
  output logic          evt_o
);
  localparam logic [CW-1:0] ALL_ONES = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          evt_q, evt_d;
  logic          reload_ok;
  logic          cnt_en;

  assign reload_ok = HAS_RELOAD && cont_i;
  assign cnt_en    = load_i | tick_i;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    evt_d   = 1'b0;
    if (load_i) begin
      cnt_d   = load_val_i;
      armed_d = 1'b1;
    end else if (tick_i) begin
      if (reload_ok && (cnt_q == ALL_ONES)) cnt_d = reload_val_i;
      else                                  cnt_d = cnt_q - 1'b1;
      if (armed_q && (cnt_d == '0) && (cnt_q != '0)) begin
        evt_d = 1'b1;
        if (!reload_ok) armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RST_VAL;
      armed_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int CONT_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              t1_evt,
  output logic              t2_evt,
  output logic              t1_flag_clr,
  output logic              t2_flag_clr
);
  localparam int DW = BYTE_W;
  localparam int CW = 2 * BYTE_W;

  logic [1:0]    rst_sync_q;
  logic          rst_n_sync;
  dit_strobes_t  stb;
  logic [CW-1:0] t1_latch_q, t1_latch_d;
  logic [DW-1:0] t2_lat_lo_q, t2_lat_lo_d;
  logic [DW-1:0] aux_q, aux_d;
  logic          t1_clr_q, t1_clr_d, t2_clr_q, t2_clr_d;
  logic [CW-1:0] t1_cnt, t2_cnt;
  logic [CW-1:0] t1_load_val, t2_load_val;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  dit_bus_decode #(.DW(DW), .CW(CW)) u_decode (
    .sel_i      (bus_sel),
    .wr_i       (bus_wr),
    .rd_i       (bus_rd),
    .addr_i     (bus_addr),
    .t1_cnt_i   (t1_cnt),
    .t1_latch_i (t1_latch_q),
    .t2_cnt_i   (t2_cnt),
    .aux_i      (aux_q),
    .stb_o      (stb),
    .rdata_o    (bus_rdata)
  );

  always_comb begin
    t1_latch_d  = t1_latch_q;
    t2_lat_lo_d = t2_lat_lo_q;
    aux_d       = aux_q;
    if (stb.t1_lo_wr)                 t1_latch_d[DW-1:0]  = bus_wdata;
    if (stb.t1_start || stb.t1_hi_wr) t1_latch_d[CW-1:DW] = bus_wdata;
    if (stb.t2_lo_wr)                 t2_lat_lo_d         = bus_wdata;
    if (stb.aux_wr)                   aux_d               = bus_wdata;
    t1_clr_d = stb.t1_start | stb.t1_hi_wr | stb.t1_lo_rd;
    t2_clr_d = stb.t2_start | stb.t2_lo_rd;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      t1_latch_q  <= '1;
      t2_lat_lo_q <= '1;
      aux_q       <= '0;
    end else begin
      if (stb.t1_lo_wr || stb.t1_start || stb.t1_hi_wr) t1_latch_q <= t1_latch_d;
      if (stb.t2_lo_wr) t2_lat_lo_q <= t2_lat_lo_d;
      if (stb.aux_wr)   aux_q       <= aux_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      t1_clr_q <= 1'b0;
      t2_clr_q <= 1'b0;
    end else begin
      t1_clr_q <= t1_clr_d;
      t2_clr_q <= t2_clr_d;
    end
  end

  assign t1_load_val = {bus_wdata, t1_latch_q[DW-1:0]};
  assign t2_load_val = {bus_wdata, t2_lat_lo_q};

  dit_count_unit #(.CW(CW), .HAS_RELOAD(1'b1), .RST_VAL('1)) u_t1 (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .tick_i       (tick_en),
    .load_i       (stb.t1_start),
    .load_val_i   (t1_load_val),
    .reload_val_i (t1_latch_q),
    .cont_i       (aux_q[CONT_BIT]),
    .cnt_o        (t1_cnt),
    .evt_o        (t1_evt)
  );

  dit_count_unit #(.CW(CW), .HAS_RELOAD(1'b0), .RST_VAL('1)) u_t2 (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .tick_i       (tick_en),
    .load_i       (stb.t2_start),
    .load_val_i   (t2_load_val),
    .reload_val_i (t2_load_val),
    .cont_i       (1'b0),
    .cnt_o        (t2_cnt),
    .evt_o        (t2_evt)
  );

  assign t1_flag_clr = t1_clr_q;
  assign t2_flag_clr = t2_clr_q;
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic              t1_evt,
  input logic              t2_evt,
  input logic              t1_flag_clr,
  input logic              t2_flag_clr,
  input logic [CW-1:0]     t1_cnt,
  input logic [CW-1:0]     t1_latch,
  input logic [CW-1:0]     t2_cnt
);
  logic t1_go, t2_go;
  assign t1_go = bus_sel & bus_wr & (bus_addr == A_T1_CHI);
  assign t2_go = bus_sel & bus_wr & (bus_addr == A_T2_HI);

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t1_go |=> (t1_cnt == {$past(bus_wdata), $past(t1_latch[DW-1:0])}));

  p_start_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t1_go |=> t1_flag_clr);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !t1_go) |=> $stable(t1_cnt));

  p_t1_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t1_evt |=> !t1_evt);

  p_t1_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    t1_evt |-> (t1_cnt == '0));

  p_t2_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t2_evt |-> (t2_cnt == '0));

  p_t2_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    t2_go |=> t2_flag_clr);

  p_rd_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && !bus_wr && bus_addr == A_T2_LO) |=> t2_flag_clr);

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd && bus_addr < A_T1_CLO) |-> (bus_rdata == '0));
endmodule

bind dual_interval_timer dit_checker #(.DW(8), .CW(16)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .tick_en     (tick_en),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .t1_evt      (t1_evt),
  .t2_evt      (t2_evt),
  .t1_flag_clr (t1_flag_clr),
  .t2_flag_clr (t2_flag_clr),
  .t1_cnt      (t1_cnt),
  .t1_latch    (t1_latch_q),
  .t2_cnt      (t2_cnt)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       t1_evt, t2_evt, t1_flag_clr, t2_flag_clr;

  int total = 0;
  int bad = 0;
  int e1, e2, f2;
  int ev1 [0:7];

  always #10 clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .t1_evt(t1_evt),
    .t2_evt(t2_evt), .t1_flag_clr(t1_flag_clr), .t2_flag_clr(t2_flag_clr)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_full(input logic [3:0] a, input logic [7:0] d, input bit tk,
                         output bit c1, output bit c2);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    c1 = t1_flag_clr; c2 = t2_flag_clr;
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bit c1, c2;
    wr_full(a, d, 1'b0, c1, c2);
  endtask

  task automatic rd_full(input logic [3:0] a, output logic [7:0] d, output bit c1, output bit c2);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    c1 = t1_flag_clr; c2 = t2_flag_clr;
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    bit c1, c2;
    rd_full(a, d, c1, c2);
    check(tag, d, exp);
  endtask

  task automatic run_ticks(input int n);
    e1 = 0; e2 = 0; f2 = 0;
    for (int k = 0; k < 8; k++) ev1[k] = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(posedge clk);
      #1;
      if (t1_evt) begin
        if (e1 < 8) ev1[e1] = i;
        e1++;
      end
      if (t2_evt) begin
        if (e2 == 0) f2 = i;
        e2++;
      end
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 t1_evt", t1_evt, 0);
    check("R1 t2_evt", t2_evt, 0);
    check("R1 t1_flag_clr", t1_flag_clr, 0);
    check("R1 t2_flag_clr", t2_flag_clr, 0);
    rd_chk("R1 t1 cnt lo", 4'd4, 8'hFF);
    rd_chk("R1 t1 cnt hi", 4'd5, 8'hFF);
    rd_chk("R1 t1 latch lo", 4'd6, 8'hFF);
    rd_chk("R1 t1 latch hi", 4'd7, 8'hFF);
    rd_chk("R1 t2 cnt lo", 4'd8, 8'hFF);
    rd_chk("R1 t2 cnt hi", 4'd9, 8'hFF);
    rd_chk("R1 aux", 4'd11, 8'h00);
  endtask

  task automatic test_low_latch();
    wr(4'd4, 8'h12);
    rd_chk("R2 cnt lo kept after addr4 write", 4'd4, 8'hFF);
    rd_chk("R2 latch lo from addr4", 4'd6, 8'h12);
    wr(4'd6, 8'h34);
    rd_chk("R2 latch lo from addr6", 4'd6, 8'h34);
    rd_chk("R2 cnt hi kept", 4'd5, 8'hFF);
  endtask

  task automatic test_one_shot();
    bit c1, c2;
    wr(4'd6, 8'h05);
    wr_full(4'd5, 8'h00, 1'b0, c1, c2);
    check("R3 clear request on start", c1, 1);
    check("R3 no t2 clear on t1 start", c2, 0);
    rd_chk("R3 loaded cnt lo", 4'd4, 8'h05);
    rd_chk("R3 loaded cnt hi", 4'd5, 8'h00);
    rd_chk("R3 latch hi", 4'd7, 8'h00);
    run_ticks(5);
    check("R6 one-shot event count", e1, 1);
    check("R6 event at tick 5", ev1[0], 5);
    rd_chk("R5 cnt reads zero", 4'd4, 8'h00);
    run_ticks(3);
    check("R7 no event after wrap", e1, 0);
    rd_chk("R7 cnt lo after wrap", 4'd4, 8'hFD);
    rd_chk("R7 cnt hi after wrap", 4'd5, 8'hFF);
  endtask

  task automatic test_start_with_tick();
    bit c1, c2;
    wr_full(4'd5, 8'h01, 1'b1, c1, c2);
    rd_chk("R3 tick ignored on start lo", 4'd4, 8'h05);
    rd_chk("R3 tick ignored on start hi", 4'd5, 8'h01);
  endtask

  task automatic test_high_latch();
    bit c1, c2;
    wr_full(4'd7, 8'h22, 1'b0, c1, c2);
    check("R4 clear request on high latch write", c1, 1);
    rd_chk("R4 cnt hi not reloaded", 4'd5, 8'h01);
    rd_chk("R4 cnt lo not reloaded", 4'd4, 8'h05);
    rd_chk("R4 latch hi updated", 4'd7, 8'h22);
  endtask

  task automatic test_free_run();
    wr(4'd11, 8'h40);
    rd_chk("R11 aux readback", 4'd11, 8'h40);
    wr(4'd6, 8'h03);
    wr(4'd5, 8'h00);
    run_ticks(13);
    check("R8 event count latch 3", e1, 3);
    check("R8 first event", ev1[0], 3);
    check("R8 second event period 5", ev1[1], 8);
    check("R8 third event", ev1[2], 13);
    wr(4'd6, 8'h00);
    wr(4'd5, 8'h00);
    run_ticks(4);
    check("R8 latch 0 event count", e1, 2);
    check("R8 latch 0 first event", ev1[0], 2);
    check("R8 latch 0 second event", ev1[1], 4);
    wr(4'd6, 8'h03);
    wr(4'd5, 8'h00);
    run_ticks(1);
    wr(4'd6, 8'h07);
    rd_chk("R2 cnt unchanged by latch write", 4'd4, 8'h02);
    run_ticks(4);
    check("R8 event before reload", ev1[0], 2);
    rd_chk("R8 reload uses new latch", 4'd4, 8'h07);
    wr(4'd11, 8'h00);
  endtask

  task automatic test_timer2();
    bit c1, c2;
    wr_full(4'd8, 8'h04, 1'b0, c1, c2);
    check("R9 low write raises no clear", c2, 0);
    rd_chk("R9 cnt hi unchanged by low write", 4'd9, 8'hFF);
    wr_full(4'd9, 8'h00, 1'b0, c1, c2);
    check("R9 clear request on start", c2, 1);
    rd_chk("R9 loaded cnt hi", 4'd9, 8'h00);
    rd_chk("R5 t2 cnt lo", 4'd8, 8'h04);
    run_ticks(7);
    check("R9 single event", e2, 1);
    check("R9 event at tick 4", f2, 4);
    rd_chk("R9 wrapped cnt lo", 4'd8, 8'hFD);
    rd_chk("R9 wrapped cnt hi", 4'd9, 8'hFF);
    wr(4'd9, 8'h00);
    run_ticks(4);
    check("R9 re-armed event", f2, 4);
  endtask

  task automatic test_read_clear();
    logic [7:0] d;
    bit c1, c2;
    rd_full(4'd4, d, c1, c2);
    check("R10 read addr4 t1 clear", c1, 1);
    rd_full(4'd5, d, c1, c2);
    check("R10 read addr5 no clear", c1, 0);
    rd_full(4'd8, d, c1, c2);
    check("R10 read addr8 t2 clear", c2, 1);
    rd_full(4'd9, d, c1, c2);
    check("R10 read addr9 no clear", c2, 0);
  endtask

  task automatic test_unmapped();
    logic [7:0] l_lo, l_hi, c_lo;
    bit c1, c2;
    rd_full(4'd6, l_lo, c1, c2);
    rd_full(4'd7, l_hi, c1, c2);
    rd_full(4'd4, c_lo, c1, c2);
    foreach (l_lo[b]) begin end
    wr(4'd0, 8'hAA);
    wr(4'd3, 8'h55);
    wr(4'd10, 8'hC3);
    wr(4'd15, 8'h3C);
    for (int a = 0; a < 16; a++) begin
      if (a < 4 || a == 10 || a > 11) rd_chk("R11 unmapped reads zero", a[3:0], 8'h00);
    end
    rd_chk("R11 latch lo untouched", 4'd6, l_lo);
    rd_chk("R11 latch hi untouched", 4'd7, l_hi);
    rd_chk("R11 cnt lo untouched", 4'd4, c_lo);
    rd_chk("R11 aux untouched", 4'd11, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_low_latch();
    test_one_shot();
    test_start_with_tick();
    test_high_latch();
    test_free_run();
    test_timer2();
    test_read_clear();
    test_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule